// File: doc/BRIEF.md
# Iterative Carry-Settling Adder

This block adds two N-bit operands and a carry-in. It does not ripple a carry through a fixed chain. A start strobe runs one parallel pass of identical half-add cells over the operands. Each later clock edge runs the same cells again on the partial sum held in a register and on the carries moved up one position. The loop ends when a completion detector finds that no carry is left. The delay therefore depends on the data. Operands whose bits never produce a carry finish after a single pass. A carry that has to run the whole width takes N+1 passes.

Each bit is carried on one wire. The block has no look-ahead logic. It reports the number of passes it took along with a one-cycle done pulse. The result stays on the outputs until the next accepted start.

Top module: `iter_settle_adder`

## Requirements
- R1: While rst_ni is low, and after it is released with no start, busy_o, done_o, cout_o, sum_o and iter_o are all zero.
- R2: A start_i sampled high while busy_o is low is accepted at that edge. From the next cycle busy_o is high and iter_o equals 1, because the operand half-add pass counts as pass 1.
- R3: When done_o is high, {cout_o, sum_o} equals a_i + b_i + cin_i as captured at the accepted start. cout_o is bit N of this sum.
- R4: done_o is high for exactly one cycle. busy_o falls at the same edge where done_o rises.
- R5: iter_o never exceeds N+1. When a_i & b_i is zero and cin_i is 0, the result takes 1 pass. An all-ones operand plus zero with cin_i = 1 takes N+1 passes.
- R6: A start_i that arrives while busy_o is high is ignored. The running addition, its pass count and its result are not disturbed, and no additional done_o pulse follows.
- R7: While idle, sum_o, cout_o and iter_o stay unchanged until the next accepted start, whatever the operand inputs do.
- R8: done_o goes high exactly iter_o clock edges after the edge that accepted the start.
- R9: The carry-in counts only in the first pass. A zero operand pair with cin_i = 1 gives sum 1 after 2 passes, and 1 + 1 with cin_i = 0 gives sum 2 after 2 passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only while idle |
| a_i | input | N | First operand |
| b_i | input | N | Second operand |
| cin_i | input | 1 | Carry-in, used in the first pass only |
| sum_o | output | N | Sum; final once done_o has pulsed |
| cout_o | output | 1 | Carry out of the top bit |
| busy_o | output | 1 | A pass loop is running |
| done_o | output | 1 | One-cycle completion pulse |
| iter_o | output | $clog2(N+2) | Number of passes taken |

## Verification
The checker captures the operands only on a start accepted while idle. It assumes that the operands of that start are valid in the cycle start_i is sampled, and that nothing else affects the result. The bench holds start_i high for exactly one cycle and drives operands in that same cycle. Before it starts a new addition it waits until busy_o is low. The only exception is one stray start during a busy period, which tests the ignore rule. Operands include random values as well as directed values whose carry paths give known pass counts.

// File: rtl/isa_pkg.sv
package isa_pkg;
  typedef enum logic {
    ISA_IDLE = 1'b0,
    ISA_RUN  = 1'b1
  } isa_state_e;
endpackage

// File: rtl/isa_half_cell.sv
module isa_half_cell (
  input  logic x_i,
  input  logic y_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i;
  assign c_o = x_i & y_i;
endmodule

// File: rtl/isa_pass_array.sv
module isa_pass_array #(
  parameter int N = 16
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  output logic [N-1:0] s_o,
  output logic [N-1:0] g_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    isa_half_cell u_cell (
      .x_i (x_i[i]),
      .y_i (y_i[i]),
      .s_o (s_o[i]),
      .c_o (g_o[i])
    );
  end
endmodule

// File: rtl/isa_zero_detect.sv
module isa_zero_detect #(
  parameter int N     = 16,
  parameter int GROUP = 4
) (
  input  logic [N-1:0] vec_i,
  output logic         zero_o
);
  localparam int NG = (N + GROUP - 1) / GROUP;
  localparam int PW = NG * GROUP;

  logic [PW-1:0] pad;
  logic [NG-1:0] grp_any;

  assign pad = PW'(vec_i);

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_any[g] = |pad[g*GROUP +: GROUP];
  end

  assign zero_o = ~|grp_any;
endmodule

// File: rtl/isa_ctrl.sv
module isa_ctrl
  import isa_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic settled_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  isa_state_e st_q, st_d;
  logic       done_q;

  assign load_o = start_i && (st_q == ISA_IDLE);
  assign step_o = (st_q == ISA_RUN) && !settled_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ISA_IDLE: if (start_i)   st_d = ISA_RUN;
      ISA_RUN:  if (settled_i) st_d = ISA_IDLE;
      default:                 st_d = ISA_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ISA_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ISA_RUN) && settled_i;
    end
  end

  assign busy_o = (st_q == ISA_RUN);
  assign done_o = done_q;
endmodule

// File: rtl/iter_settle_adder.sv
module iter_settle_adder #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 2)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [N-1:0]  a_i,
  input  logic [N-1:0]  b_i,
  input  logic          cin_i,
  output logic [N-1:0]  sum_o,
  output logic          cout_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] iter_o
);
  logic [N-1:0]  s_q, cl_q;
  logic          cout_q;
  logic [CW-1:0] iter_q;
  logic [N-1:0]  x, y, s_nxt, g_nxt;
  logic          load, step, settled;

  // first pass reuses the same cells on the operands
  assign x = load ? a_i : s_q;
  assign y = load ? b_i : cl_q;

  isa_pass_array #(.N(N)) u_array (
    .x_i (x),
    .y_i (y),
    .s_o (s_nxt),
    .g_o (g_nxt)
  );

  isa_zero_detect #(.N(N)) u_detect (
    .vec_i  (cl_q),
    .zero_o (settled)
  );

  isa_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .settled_i (settled),
    .load_o    (load),
    .step_o    (step),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  // cl_q holds the carry arriving at each bit; top carry goes straight to cout
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_q    <= '0;
      cl_q   <= '0;
      cout_q <= 1'b0;
      iter_q <= '0;
    end else if (load) begin
      s_q    <= s_nxt;
      cl_q   <= {g_nxt[N-2:0], cin_i};
      cout_q <= g_nxt[N-1];
      iter_q <= CW'(1);
    end else if (step) begin
      s_q    <= s_nxt;
      cl_q   <= {g_nxt[N-2:0], 1'b0};
      cout_q <= cout_q | g_nxt[N-1];
      iter_q <= iter_q + CW'(1);
    end
  end

  assign sum_o  = s_q;
  assign cout_o = cout_q;
  assign iter_o = iter_q;
endmodule

// File: rtl/iter_settle_adder_chk.sv
module iter_settle_adder_chk #(
  parameter int N  = 16,
  parameter int CW = $clog2(N + 2)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [N-1:0]  a_i,
  input logic [N-1:0]  b_i,
  input logic          cin_i,
  input logic [N-1:0]  sum_o,
  input logic          cout_o,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] iter_o
);
  localparam logic [CW-1:0] ITER_MAX = CW'(N + 1);

  logic [N:0] exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) exp_q <= '0;
    else if (start_i && !busy_o) exp_q <= {1'b0, a_i} + {1'b0, b_i} + {{N{1'b0}}, cin_i};
  end

  a_r1_reset_idle: assert property (@(posedge clk_i) !rst_ni |=> !busy_o && !done_o);

  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && iter_o == CW'(1)));

  a_r3_sum_correct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({cout_o, sum_o} == exp_q));

  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r4_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r5_iter_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iter_o <= ITER_MAX);

  a_r6_busy_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !$fell(busy_o)) |=> (iter_o != CW'(1)) || !busy_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(sum_o) && $stable(cout_o) && $stable(iter_o)));
endmodule

bind iter_settle_adder iter_settle_adder_chk #(.N(N), .CW(CW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .iter_o  (iter_o)
);

// File: tb/iter_settle_adder_test.sv
module iter_settle_adder_test;
  localparam int N  = 16;
  localparam int CW = $clog2(N + 2);

  typedef struct {
    logic [N:0] sum;
    int         iter;   // 0 = any value within bound
    int         t0;
  } exp_t;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [N-1:0]  a_i = '0, b_i = '0;
  logic          cin_i = 1'b0;
  logic [N-1:0]  sum_o;
  logic          cout_o, busy_o, done_o;
  logic [CW-1:0] iter_o;

  int   checks = 0, failures = 0, cyc = 0;
  bit   prev_done = 1'b0;
  exp_t sb[$];

  iter_settle_adder #(.N(N)) uut (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_add(input logic [N-1:0] a, input logic [N-1:0] b, input logic c, input int it);
    exp_t e;
    while (busy_o) @(negedge clk_i);
    e.sum  = {1'b0, a} + {1'b0, b} + {{N{1'b0}}, c};
    e.iter = it;
    e.t0   = cyc + 1;
    sb.push_back(e);
    start_i = 1'b1; a_i = a; b_i = b; cin_i = c;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1 && iter_o == CW'(1), "R2", {busy_o, iter_o}, {1'b1, CW'(1)});
  endtask

  task automatic wait_idle();
    while (busy_o || sb.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_done) chk(done_o === 1'b0, "R4", done_o, 0);
      if (done_o) begin
        chk(busy_o === 1'b0, "R4", busy_o, 0);
        if (sb.size() == 0) begin
          chk(1'b0, "R6", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk({cout_o, sum_o} === e.sum, "R3", {cout_o, sum_o}, e.sum);
          chk(int'(iter_o) <= N + 1, "R5", iter_o, N + 1);
          if (e.iter != 0) chk(int'(iter_o) == e.iter, "R5/R9", iter_o, e.iter);
          chk(cyc - e.t0 == int'(iter_o), "R8", cyc - e.t0, iter_o);
        end
      end
      prev_done <= done_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] h_sum;
    logic         h_cout;
    logic [CW-1:0] h_iter;
    repeat (3) @(negedge clk_i);
    chk({busy_o, done_o, cout_o, sum_o, iter_o} === '0, "R1", {busy_o, done_o, cout_o, sum_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({busy_o, done_o, cout_o, sum_o, iter_o} === '0, "R1", {busy_o, done_o, cout_o, sum_o}, 0);

    run_add('0, '0, 1'b0, 1);                       // R5 zero plus zero
    run_add(16'hA5A5, 16'h5A5A, 1'b0, 1);           // R5 disjoint bits
    run_add('1, '0, 1'b1, N + 1);                   // R5 worst case
    run_add('1, 16'h0001, 1'b0, N);                 // all-ones plus one
    run_add('0, '0, 1'b1, 2);                       // R9 carry-in alone
    run_add(16'h0001, 16'h0001, 1'b0, 2);           // R9
    run_add('1, '1, 1'b1, 0);
    wait_idle();

    // R6: stray start while busy
    run_add('1, '0, 1'b1, N + 1);
    start_i = 1'b1; a_i = 16'h1234; b_i = 16'h0001; cin_i = 1'b0;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1 && iter_o == CW'(2), "R6", iter_o, 2);
    wait_idle();

    // R7: outputs hold while idle
    h_sum = sum_o; h_cout = cout_o; h_iter = iter_o;
    a_i = 16'hBEEF; b_i = 16'h1111; cin_i = 1'b1;
    repeat (6) @(negedge clk_i);
    chk({h_cout, h_sum, h_iter} === {cout_o, sum_o, iter_o}, "R7", {cout_o, sum_o}, {h_cout, h_sum});

    for (int k = 0; k < 60; k++) begin
      run_add(N'($urandom), N'($urandom), 1'($urandom), 0);
      if (k % 7 == 0) repeat (3) @(negedge clk_i);
    end
    wait_idle();
    chk(sb.size() == 0, "R6", sb.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule